// File: doc/BRIEF.md
# Line-Fill Cacheability Controller

This block sits beside the memory controller and judges every processor memory cycle for caching. When the address strobe is seen, it captures the cycle address, the code/data and read/write attributes and the system-management flag. In the following clock it presents four decisions. The first is an active-low first-level cache-enable. The second is a permit for the second-level cache to fill (and so replace) a line. The third is a permit to write back the dirty victim of that replacement. The fourth is a second-level write-inhibit for protected shadow memory.

Cacheability only gates line fills. Hits in the second-level cache, including code fetches that land on lines made dirty by earlier data writes, are never blocked. The block has no say over hit/miss. It only refuses to allocate. The tag lookup result and the victim's dirty state arrive from outside in the decision cycle. The installed DRAM size and the tag-limited cacheable range are supplied as static inputs. Shadow, protection, code/data mode, the system-management block and the programmable memory windows live in a small indexed configuration register file.

Top module: `fillc_ctrl`

## Requirements
- R1: `ken_n` is high out of reset and in every cycle that does not directly follow an address strobe; the three active-high outputs are then low.
- R2: An address whose 64 KB block number is below `dram_blocks` and outside the shadow region is first-level cacheable; an address at or above that block count is neither first-level cacheable nor second-level fillable unless a memory window says otherwise.
- R3: A second-level fill requires `cyc_addr >> l2_lim` to be zero; DRAM above that limit remains first-level cacheable.
- R4: The shadow region 0xA0000–0xFFFFF is first-level cacheable only when control bit 0 is set and second-level fillable only when control bit 1 is set.
- R5: Window w uses index 2+2w for its base block (bits 7:0) and index 3+2w for its length in blocks (bits 8:0), cacheable flag (bit 14) and active flag (bit 15). An active cacheable window makes its area first-level cacheable even outside DRAM without allowing a second-level fill. An active non-cacheable window blocks both. The lowest-numbered hitting window decides.
- R6: Control bits 4:3 select the code/data mode: 00 and 11 unified, 01 data-only, 10 code-only. A read miss of the excluded kind gets no fill permit and no writeback permit, while `ken_n` is unaffected.
- R7: `l2_fill_ok` is only asserted for a read that misses (`l2_hit` low); hits and writes never replace a line.
- R8: `wb_ok` is asserted exactly when a fill is permitted and `victim_dirty` is high.
- R9: When control bit 2 is set, a write into the shadow region asserts `l2_wr_inh`; reads and writes elsewhere do not.
- R10: With `smm_active` captured high, an address in the block held at index 1 (bits 7:0) gets `ken_n` high and no fill.
- R11: Configuration writes through `cfg_we`/`cfg_idx`/`cfg_wdata` take effect from the next cycle; after reset all configuration is zero (unified mode, shadow uncached, no windows).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| ads | input | 1 | Address strobe; captures the cycle attributes |
| cyc_addr | input | 24 | Cycle byte address |
| cyc_code | input | 1 | 1 = code fetch, 0 = data |
| cyc_write | input | 1 | 1 = write, 0 = read |
| smm_active | input | 1 | System-management mode active for this cycle |
| dram_blocks | input | 9 | Installed DRAM in 64 KB blocks |
| l2_lim | input | 5 | log2 of the second-level cacheable range in bytes |
| l2_hit | input | 1 | Second-level tag hit, in the decision cycle |
| victim_dirty | input | 1 | Line that a fill would replace is dirty |
| ken_n | output | 1 | First-level cache-enable, active low |
| l2_fill_ok | output | 1 | Second-level line fill / replacement permitted |
| wb_ok | output | 1 | Writeback of the dirty victim permitted |
| l2_wr_inh | output | 1 | Block the second-level write for this cycle |

## Verification
The bench hunts the edges where the rules overlap. These are the last DRAM block against the first block beyond it, an address one byte under and at the tag limit, and a shadow address with only one of its two enable bits set. It also covers two windows covering the same block with opposite cacheable flags, and an SMM block that is ordinary DRAM when the flag is clear. A design with an off-by-one DRAM or limit compare would fill beyond memory or refuse the top block. Swapped shadow bits would fill the wrong cache level, and reversed window priority would cache a region meant to be blocked. Code fetch misses in data-only mode and hits in every mode are driven as well, so a design that filtered hits by mode or still wrote back the victim on a refused fill is caught.

// File: rtl/fillc_pkg.sv
package fillc_pkg;

    typedef enum logic [1:0] {
        MODE_UNIFIED = 2'b00,
        MODE_DATA    = 2'b01,
        MODE_CODE    = 2'b10,
        MODE_UNI_ALT = 2'b11
    } fill_mode_e;

    // control register layout: [4:3] mode, [2] shadow write-protect,
    // [1] shadow L2 cacheable, [0] shadow L1 cacheable
    typedef struct packed {
        fill_mode_e mode;
        logic       sh_wp;
        logic       sh_l2;
        logic       sh_l1;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // classification of the captured address
    typedef struct packed {
        logic in_smm;
        logic win_hit;
        logic win_cache;
        logic in_shadow;
        logic in_dram;
        logic below_lim;
    } region_t;

    localparam logic [31:0] SHADOW_LO = 32'h000A_0000;
    localparam logic [31:0] SHADOW_HI = 32'h000F_FFFF;

    localparam int IDX_CTRL = 0;
    localparam int IDX_SMM  = 1;
    localparam int IDX_WIN0 = 2;

    function automatic logic mode_allows(fill_mode_e m, logic is_code);
        case (m)
            MODE_DATA: return !is_code;
            MODE_CODE: return is_code;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fillc_cfg_regs.sv
module fillc_cfg_regs
    import fillc_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter int NWIN  = 2,
    parameter int IDX_W = 4,
    parameter int DW    = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DW-1:0]                  wdata,
    output ctrl_t                          ctrl,
    output logic [BLK_W-1:0]               smm_blk,
    output logic [NWIN-1:0][BLK_W-1:0]     win_base,
    output logic [NWIN-1:0][BLK_W:0]       win_len,
    output logic [NWIN-1:0]                win_cach,
    output logic [NWIN-1:0]                win_act
);
    localparam int LEN_W = BLK_W + 1;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            smm_blk <= '0;
        end else if (we) begin
            if (idx == IDX_W'(IDX_CTRL)) ctrl    <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (idx == IDX_W'(IDX_SMM))  smm_blk <= wdata[BLK_W-1:0];
        end
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(IDX_WIN0 + 2*w);
        localparam logic [IDX_W-1:0] ATTR_IDX = IDX_W'(IDX_WIN0 + 2*w + 1);
        always_ff @(posedge clk) begin
            if (rst) begin
                win_base[w] <= '0;
                win_len[w]  <= '0;
                win_cach[w] <= 1'b0;
                win_act[w]  <= 1'b0;
            end else if (we) begin
                if (idx == BASE_IDX) win_base[w] <= wdata[BLK_W-1:0];
                if (idx == ATTR_IDX) begin
                    win_len[w]  <= wdata[LEN_W-1:0];
                    win_cach[w] <= wdata[DW-2];
                    win_act[w]  <= wdata[DW-1];
                end
            end
        end
    end

endmodule

// File: rtl/fillc_region.sv
module fillc_region
    import fillc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BLK_SH = 16,
    parameter int NWIN   = 2,
    parameter int LIM_W  = 5
) (
    input  logic [ADDR_W-1:0]                     addr,
    input  logic                                  smm,
    input  logic [ADDR_W-BLK_SH:0]                dram_blocks,
    input  logic [LIM_W-1:0]                      lim,
    input  logic [ADDR_W-BLK_SH-1:0]              smm_blk,
    input  logic [NWIN-1:0][ADDR_W-BLK_SH-1:0]    win_base,
    input  logic [NWIN-1:0][ADDR_W-BLK_SH:0]      win_len,
    input  logic [NWIN-1:0]                       win_cach,
    input  logic [NWIN-1:0]                       win_act,
    output region_t                               rgn
);
    localparam int BLK_W = ADDR_W - BLK_SH;

    logic [BLK_W-1:0] blk;
    logic [NWIN-1:0]  hit;
    logic             sel_cache;

    assign blk = addr[ADDR_W-1:BLK_SH];

    for (genvar w = 0; w < NWIN; w++) begin : g_hit
        logic [BLK_W:0] offs;
        assign offs   = {1'b0, blk} - {1'b0, win_base[w]};
        assign hit[w] = win_act[w] && (offs < win_len[w]);
    end

    // lowest index wins: scan downward so the last match is the lowest
    always_comb begin
        sel_cache = 1'b0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) sel_cache = win_cach[i];
        end
    end

    always_comb begin
        rgn           = '0;
        rgn.in_smm    = smm && (blk == smm_blk);
        rgn.win_hit   = |hit;
        rgn.win_cache = sel_cache;
        rgn.in_shadow = (32'(addr) >= SHADOW_LO) && (32'(addr) <= SHADOW_HI);
        rgn.in_dram   = ({1'b0, blk} < dram_blocks);
        rgn.below_lim = ((addr >> lim) == '0);
    end

endmodule

// File: rtl/fillc_policy.sv
module fillc_policy
    import fillc_pkg::*;
(
    input  logic    vld,
    input  region_t rgn,
    input  ctrl_t   ctrl,
    input  logic    is_code,
    input  logic    is_write,
    input  logic    l2_hit,
    input  logic    victim_dirty,
    output logic    ken_n,
    output logic    l2_fill_ok,
    output logic    wb_ok,
    output logic    l2_wr_inh
);
    logic l1_ok;
    logic l2_ok;
    logic win_block;

    assign win_block = rgn.win_hit && !rgn.win_cache;

    always_comb begin
        if (rgn.in_smm)         l1_ok = 1'b0;
        else if (rgn.win_hit)   l1_ok = rgn.win_cache;
        else if (rgn.in_shadow) l1_ok = ctrl.sh_l1;
        else                    l1_ok = rgn.in_dram;
    end

    always_comb begin
        if (rgn.in_smm || win_block || !rgn.below_lim) l2_ok = 1'b0;
        else if (rgn.in_shadow)                         l2_ok = ctrl.sh_l2;
        else                                            l2_ok = rgn.in_dram;
    end

    assign ken_n      = !(vld && l1_ok);
    assign l2_fill_ok = vld && l2_ok && !is_write && !l2_hit
                        && mode_allows(ctrl.mode, is_code);
    assign wb_ok      = l2_fill_ok && victim_dirty;
    assign l2_wr_inh  = vld && is_write && rgn.in_shadow && ctrl.sh_wp;

endmodule

// File: rtl/fillc_ctrl.sv
module fillc_ctrl
    import fillc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BLK_SH = 16,
    parameter int NWIN   = 2,
    parameter int IDX_W  = 4,
    parameter int DW     = 16,
    localparam int BLK_W = ADDR_W - BLK_SH,
    localparam int LIM_W = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              ads,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_code,
    input  logic              cyc_write,
    input  logic              smm_active,
    input  logic [BLK_W:0]    dram_blocks,
    input  logic [LIM_W-1:0]  l2_lim,
    input  logic              l2_hit,
    input  logic              victim_dirty,
    output logic              ken_n,
    output logic              l2_fill_ok,
    output logic              wb_ok,
    output logic              l2_wr_inh
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              code;
        logic              wr;
        logic              smm;
    } cyc_t;

    cyc_t                          cyc_q;
    logic                          vld_q;
    ctrl_t                         ctrl;
    logic [BLK_W-1:0]              smm_blk;
    logic [NWIN-1:0][BLK_W-1:0]    win_base;
    logic [NWIN-1:0][BLK_W:0]      win_len;
    logic [NWIN-1:0]               win_cach;
    logic [NWIN-1:0]               win_act;
    region_t                       rgn;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cyc_q <= '0;
        end else begin
            vld_q <= ads;
            if (ads) cyc_q <= '{addr: cyc_addr, code: cyc_code,
                                wr: cyc_write, smm: smm_active};
        end
    end

    fillc_cfg_regs #(.BLK_W(BLK_W), .NWIN(NWIN), .IDX_W(IDX_W), .DW(DW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .ctrl     (ctrl),
        .smm_blk  (smm_blk),
        .win_base (win_base),
        .win_len  (win_len),
        .win_cach (win_cach),
        .win_act  (win_act)
    );

    fillc_region #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .NWIN(NWIN), .LIM_W(LIM_W)) u_rgn (
        .addr        (cyc_q.addr),
        .smm         (cyc_q.smm),
        .dram_blocks (dram_blocks),
        .lim         (l2_lim),
        .smm_blk     (smm_blk),
        .win_base    (win_base),
        .win_len     (win_len),
        .win_cach    (win_cach),
        .win_act     (win_act),
        .rgn         (rgn)
    );

    fillc_policy u_pol (
        .vld          (vld_q),
        .rgn          (rgn),
        .ctrl         (ctrl),
        .is_code      (cyc_q.code),
        .is_write     (cyc_q.wr),
        .l2_hit       (l2_hit),
        .victim_dirty (victim_dirty),
        .ken_n        (ken_n),
        .l2_fill_ok   (l2_fill_ok),
        .wb_ok        (wb_ok),
        .l2_wr_inh    (l2_wr_inh)
    );

endmodule

// File: rtl/fillc_ctrl_chk.sv
module fillc_ctrl_chk #(
    parameter int ADDR_W = 24,
    parameter int BLK_SH = 16,
    parameter int LIM_W  = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ads,
    input logic [ADDR_W-1:0]        cyc_addr,
    input logic                     cyc_write,
    input logic                     smm_active,
    input logic [LIM_W-1:0]         l2_lim,
    input logic                     l2_hit,
    input logic                     victim_dirty,
    input logic [ADDR_W-BLK_SH-1:0] smm_blk,
    input logic                     ken_n,
    input logic                     l2_fill_ok,
    input logic                     wb_ok,
    input logic                     l2_wr_inh
);
    // R1: no strobe in the previous cycle means idle outputs
    a_r1_idle_ken: assert property (@(posedge clk) disable iff (rst)
        !$past(ads) |-> (ken_n && !l2_fill_ok && !l2_wr_inh));

    // R7: a fill permit follows a strobed read that missed
    a_r7_fill_read_miss: assert property (@(posedge clk) disable iff (rst)
        l2_fill_ok |-> ($past(ads) && !$past(cyc_write) && !l2_hit));

    // R8: writeback only alongside a fill of a dirty victim
    a_r8_wb_needs_fill: assert property (@(posedge clk) disable iff (rst)
        wb_ok |-> (l2_fill_ok && victim_dirty));

    // R9: write-inhibit only for a strobed write
    a_r9_inh_on_write: assert property (@(posedge clk) disable iff (rst)
        l2_wr_inh |-> ($past(ads) && $past(cyc_write)));

    // R3: fill only below the tag limit
    a_r3_below_limit: assert property (@(posedge clk) disable iff (rst)
        l2_fill_ok |-> (($past(cyc_addr) >> l2_lim) == '0));

    // R10: no fill inside the SMM block while SMM is active
    a_r10_smm_block: assert property (@(posedge clk) disable iff (rst)
        l2_fill_ok |-> !($past(smm_active) &&
                         ($past(cyc_addr[ADDR_W-1:BLK_SH]) == smm_blk)));

endmodule

bind fillc_ctrl fillc_ctrl_chk #(.ADDR_W(ADDR_W), .BLK_SH(BLK_SH), .LIM_W(LIM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ads          (ads),
    .cyc_addr     (cyc_addr),
    .cyc_write    (cyc_write),
    .smm_active   (smm_active),
    .l2_lim       (l2_lim),
    .l2_hit       (l2_hit),
    .victim_dirty (victim_dirty),
    .smm_blk      (smm_blk),
    .ken_n        (ken_n),
    .l2_fill_ok   (l2_fill_ok),
    .wb_ok        (wb_ok),
    .l2_wr_inh    (l2_wr_inh)
);

// File: tb/fillc_ctrl_tb.sv
`timescale 1ns/1ps
module fillc_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic        ads = 1'b0;
    logic [23:0] cyc_addr = '0;
    logic        cyc_code = 1'b0;
    logic        cyc_write = 1'b0;
    logic        smm_active = 1'b0;
    logic [8:0]  dram_blocks = 9'd64;
    logic [4:0]  l2_lim = 5'd21;
    logic        l2_hit = 1'b0;
    logic        victim_dirty = 1'b0;
    logic        ken_n, l2_fill_ok, wb_ok, l2_wr_inh;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model copies of configuration
    bit       m_sh_l1, m_sh_l2, m_sh_wp;
    int       m_mode;
    int       m_smm_blk;
    int       m_wbase[2];
    int       m_wlen[2];
    bit       m_wcach[2];
    bit       m_wact[2];

    always #2.5 clk = ~clk;

    fillc_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .ads(ads), .cyc_addr(cyc_addr),
        .cyc_code(cyc_code), .cyc_write(cyc_write), .smm_active(smm_active),
        .dram_blocks(dram_blocks), .l2_lim(l2_lim), .l2_hit(l2_hit),
        .victim_dirty(victim_dirty), .ken_n(ken_n), .l2_fill_ok(l2_fill_ok),
        .wb_ok(wb_ok), .l2_wr_inh(l2_wr_inh)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(int idx, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (idx)
            0: begin m_sh_l1 = d[0]; m_sh_l2 = d[1]; m_sh_wp = d[2]; m_mode = int'(d[4:3]); end
            1: m_smm_blk = int'(d[7:0]);
            2, 4: m_wbase[(idx-2)/2] = int'(d[7:0]);
            3, 5: begin
                m_wlen[(idx-3)/2]  = int'(d[8:0]);
                m_wcach[(idx-3)/2] = d[14];
                m_wact[(idx-3)/2]  = d[15];
            end
            default: ;
        endcase
    endtask

    // behavioural expectation from the requirements
    task automatic expect_of(int a, bit code, bit wr, bit smm, bit hit, bit dirty,
                             output bit e_ken_n, output bit e_fill,
                             output bit e_wb, output bit e_inh);
        int  blk = a / 65536;
        bit  in_smm = smm && (blk == m_smm_blk);
        bit  shadow = (a >= 'hA0000) && (a <= 'hFFFFF);
        bit  dram = blk < int'(dram_blocks);
        bit  below = (a >> l2_lim) == 0;
        int  w_sel = -1;
        bit  l1, l2, mode_ok;
        for (int w = 0; w < 2; w++)
            if (w_sel < 0 && m_wact[w] && blk >= m_wbase[w] && blk < m_wbase[w] + m_wlen[w])
                w_sel = w;
        if (in_smm) l1 = 0;
        else if (w_sel >= 0) l1 = m_wcach[w_sel];
        else if (shadow) l1 = m_sh_l1;
        else l1 = dram;
        if (in_smm || (w_sel >= 0 && !m_wcach[w_sel]) || !below) l2 = 0;
        else if (shadow) l2 = m_sh_l2;
        else l2 = dram;
        mode_ok = (m_mode == 1) ? !code : (m_mode == 2) ? code : 1'b1;
        e_ken_n = !l1;
        e_fill  = l2 && !wr && !hit && mode_ok;
        e_wb    = e_fill && dirty;
        e_inh   = wr && shadow && m_sh_wp;
    endtask

    task automatic issue(string req, int a, bit code, bit wr, bit smm, bit hit, bit dirty);
        bit ek, ef, ew, ei;
        @(negedge clk);
        ads = 1'b1; cyc_addr = 24'(a); cyc_code = code; cyc_write = wr;
        smm_active = smm; l2_hit = 1'b0; victim_dirty = 1'b0;
        #1;
        chk("R1", "idle ken_n", ken_n, 1'b1);
        chk("R1", "idle fill", l2_fill_ok, 1'b0);
        @(negedge clk);
        ads = 1'b0; l2_hit = hit; victim_dirty = dirty;
        cyc_addr = '0; cyc_code = 1'b0; cyc_write = 1'b0; smm_active = 1'b0;
        #1;
        expect_of(a, code, wr, smm, hit, dirty, ek, ef, ew, ei);
        chk(req, "ken_n", ken_n, ek);
        chk(req, "l2_fill_ok", l2_fill_ok, ef);
        chk(req, "wb_ok", wb_ok, ew);
        chk(req, "l2_wr_inh", l2_wr_inh, ei);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 / R1: reset state
        chk("R11", "reset ken_n", ken_n, 1'b1);
        chk("R11", "reset fill", l2_fill_ok, 1'b0);
        chk("R11", "reset wb", wb_ok, 1'b0);
        chk("R11", "reset inh", l2_wr_inh, 1'b0);

        // R2 plain DRAM, R8 dirty victim
        issue("R2", 'h010000, 0, 0, 0, 0, 1);
        issue("R8", 'h010000, 0, 0, 0, 0, 0);
        issue("R7", 'h010000, 0, 0, 0, 1, 1);     // read hit: no fill
        issue("R7", 'h010000, 0, 1, 0, 0, 1);     // write miss: no fill
        // R2 DRAM boundary
        issue("R2", 'h3F0000, 0, 0, 0, 0, 0);     // block 63: ken, above limit
        issue("R2", 'h400000, 0, 0, 0, 0, 0);     // block 64: beyond DRAM
        // R3 limit boundary at 2 MB
        issue("R3", 'h1FFFFF, 0, 0, 0, 0, 0);
        issue("R3", 'h200000, 0, 0, 0, 0, 1);
        // R4 shadow
        issue("R4", 'h0C0000, 0, 0, 0, 0, 0);
        cfg_write(0, 16'h0001);
        issue("R4", 'h0C0000, 0, 0, 0, 0, 0);
        cfg_write(0, 16'h0002);
        issue("R4", 'h0A0000, 0, 0, 0, 0, 0);
        issue("R4", 'h09FFFF, 0, 0, 0, 0, 0);
        cfg_write(0, 16'h0003);
        issue("R4", 'h0FFFFF, 1, 0, 0, 0, 1);
        // R9 write protect
        cfg_write(0, 16'h0007);
        issue("R9", 'h0C0000, 0, 1, 0, 0, 0);
        issue("R9", 'h0C0000, 0, 0, 0, 0, 0);
        issue("R9", 'h010000, 0, 1, 0, 0, 0);
        // R6 code/data modes
        cfg_write(0, 16'h0008);                   // data-only
        issue("R6", 'h020000, 1, 0, 0, 0, 1);
        issue("R6", 'h020000, 0, 0, 0, 0, 1);
        issue("R7", 'h020000, 1, 0, 0, 1, 1);     // code hit still serviced, no fill
        cfg_write(0, 16'h0010);                   // code-only
        issue("R6", 'h020000, 1, 0, 0, 0, 1);
        issue("R6", 'h020000, 0, 0, 0, 0, 1);
        cfg_write(0, 16'h0018);                   // alternate unified
        issue("R6", 'h020000, 1, 0, 0, 0, 0);
        issue("R6", 'h020000, 0, 0, 0, 0, 0);
        cfg_write(0, 16'h0000);
        // R5 windows
        cfg_write(2, 16'h0060);
        cfg_write(3, 16'hC002);                   // win0: blocks 0x60-0x61, cacheable
        issue("R5", 'h600000, 0, 0, 0, 0, 0);
        issue("R5", 'h610000, 0, 0, 0, 0, 0);
        issue("R5", 'h620000, 0, 0, 0, 0, 0);
        cfg_write(4, 16'h0060);
        cfg_write(5, 16'h8001);                   // win1: block 0x60, blocking
        issue("R5", 'h600000, 0, 0, 0, 0, 0);     // win0 wins
        cfg_write(4, 16'h0002);                   // win1 moves into DRAM
        issue("R5", 'h020000, 0, 0, 0, 0, 1);
        issue("R5", 'h030000, 0, 0, 0, 0, 0);
        // R10 SMM
        cfg_write(1, 16'h0003);
        issue("R10", 'h030000, 0, 0, 1, 0, 1);
        issue("R10", 'h030000, 0, 0, 0, 0, 1);
        issue("R10", 'h040000, 0, 0, 1, 0, 0);
        // R2 with smaller DRAM
        dram_blocks = 9'd4;
        issue("R2", 'h040000, 0, 0, 0, 0, 0);
        issue("R2", 'h030000, 0, 0, 0, 0, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule